// File: doc/BRIEF.md
# Feedforward Convolutional Encoder with Parallel Code Output

This block adds redundancy to a serial bit stream ahead of a modulator. Each accepted input bit is combined with a window of the most recently accepted bits. The block then produces one coded word per accepted bit, with one code bit for each generator polynomial. A Viterbi-style decoder at the far end uses this redundancy to correct channel errors.

The following are compile-time parameters:
- the constraint length `K` (3 to 12),
- the number of code bits `N_OUT` (2 to 8),
- the flattened polynomial vector `POLYS`.

The defaults give the widely used rate-1/2, K=7 code with polynomials 171 and 133 (octal).

The stream interface has a valid strobe and no ready, because the encoder never stalls. A bit is taken on every cycle that `in_valid` is high. A coded word leaves the block a fixed number of cycles later, and the sink must capture every word flagged by `out_valid`. Idle cycles on the input pass straight through as idle cycles on the output. They do not disturb the code history.

Top module: `conv_encoder`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `out_valid` is 0 and `out_code` is all zeros.
- R2: `out_valid` in cycle n+L equals `in_valid` in cycle n, where L=3 when K>4 and L=2 otherwise. Every accepted bit yields exactly one valid word, in order, with no back-pressure.
- R3: For each accepted bit, form a K-bit window. Bit K-1 is the current input. Bit K-2 is the most recently accepted earlier bit, and so on down to bit 0, which is the oldest. Code bit i is the XOR of the window bits at the positions where polynomial i has a 1. Positions where polynomial i has a 0 do not contribute.
- R4: Polynomial i occupies `POLYS[i*K +: K]` and drives `out_code[i]`, so output 0 is the LSB. The word has `N_OUT` bits, one for each polynomial, with `N_OUT` from 2 to 8.
- R5: The history advances only on cycles with `in_valid` high. Idle cycles between bits leave the coded sequence identical to the same bits sent back to back.
- R6: While `out_valid` is low, `out_code` keeps the last valid word (zero after reset).
- R7: Reset clears the history, so the first words after reset are computed with an all-zero past.
- R8: The value on `in_bit` has no effect in cycles where `in_valid` is low.
- R9: With default parameters the block is the K=7, rate-1/2 code with polynomials 171 and 133 (octal), with latency 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input bit per cycle at most |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit | input | 1 | Serial data bit |
| in_valid | input | 1 | `in_bit` is taken this cycle |
| out_code | output | N_OUT | Coded word, bit i from polynomial i |
| out_valid | output | 1 | `out_code` holds a new word this cycle |

## Verification
The assertions check four things on every cycle:
- that the output valid is the input valid delayed by exactly the latency,
- that the word is frozen while invalid,
- that outputs are quiet in reset,
- that any window of all-zero history with a zero input yields a zero word. This last check also covers the cleared history after reset.

The bench's scenarios are the only evidence for the actual tap mapping and the polynomial-to-bit order. They compare each word against an independent model, for three configurations (K=3, K=5 with three outputs, and the default K=7). They also show that gaps and garbage on the idle input leave the sequence unchanged, and that a mid-stream reset drops words in flight.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int unsigned MIN_K     = 3;
  localparam int unsigned MAX_K     = 12;
  localparam int unsigned MIN_OUTS  = 2;
  localparam int unsigned MAX_OUTS  = 8;
  // constraint lengths above this get one extra output stage
  localparam int unsigned SHORT_K_MAX = 4;

  function automatic int unsigned enc_latency(input int unsigned k);
    return (k > SHORT_K_MAX) ? 3 : 2;
  endfunction
endpackage

// File: rtl/conv_enc_in_reg.sv
module conv_enc_in_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_d,
  input  logic vld_d,
  output logic bit_q,
  output logic vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      // keep the data bit unchanged on idle cycles
      if (vld_d) bit_q <= bit_d;
    end
  end
endmodule

// File: rtl/conv_enc_history.sv
module conv_enc_history #(
  parameter int unsigned K = 7,
  localparam int unsigned HW = K - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          new_bit,
  output logic [HW-1:0] hist
);
  // hist[HW-1] is the most recent accepted bit, hist[0] the oldest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {new_bit, hist[HW-1:1]};
  end
endmodule

// File: rtl/conv_enc_taps.sv
module conv_enc_taps #(
  parameter int unsigned K     = 7,
  parameter int unsigned N_OUT = 2,
  parameter logic [N_OUT*K-1:0] POLYS = '0
) (
  input  logic [K-1:0]     window,
  output logic [N_OUT-1:0] code
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_poly
    localparam logic [K-1:0] P = POLYS[g*K +: K];
    assign code[g] = ^(window & P);
  end
endmodule

// File: rtl/conv_enc_out_pipe.sv
module conv_enc_out_pipe #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic         v_in,
  output logic [W-1:0] d_out,
  output logic         v_out
);
  logic [W-1:0]      d_q [STAGES];
  logic [STAGES-1:0] v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) d_q[s] <= '0;
      v_q <= '0;
    end else begin
      v_q[0] <= v_in;
      if (v_in) d_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) begin
        v_q[s] <= v_q[s-1];
        if (v_q[s-1]) d_q[s] <= d_q[s-1];
      end
    end
  end

  assign d_out = d_q[STAGES-1];
  assign v_out = v_q[STAGES-1];
endmodule

// File: rtl/conv_encoder.sv
module conv_encoder
  import conv_enc_pkg::*;
#(
  parameter int unsigned K     = 7,
  parameter int unsigned N_OUT = 2,
  parameter logic [N_OUT*K-1:0] POLYS = {7'o133, 7'o171}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_bit,
  input  logic             in_valid,
  output logic [N_OUT-1:0] out_code,
  output logic             out_valid
);
  localparam int unsigned LAT        = enc_latency(K);
  localparam int unsigned OUT_STAGES = LAT - 1;

  logic           cur_bit, cur_vld;
  logic [K-2:0]   hist;
  logic [N_OUT-1:0] code_c;

  conv_enc_in_reg u_in (
    .clk(clk), .rst_n(rst_n),
    .bit_d(in_bit), .vld_d(in_valid),
    .bit_q(cur_bit), .vld_q(cur_vld)
  );

  conv_enc_history #(.K(K)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(cur_vld), .new_bit(cur_bit), .hist(hist)
  );

  conv_enc_taps #(.K(K), .N_OUT(N_OUT), .POLYS(POLYS)) u_taps (
    .window({cur_bit, hist}), .code(code_c)
  );

  conv_enc_out_pipe #(.W(N_OUT), .STAGES(OUT_STAGES)) u_out (
    .clk(clk), .rst_n(rst_n),
    .d_in(code_c), .v_in(cur_vld),
    .d_out(out_code), .v_out(out_valid)
  );
endmodule

// File: rtl/conv_encoder_chk.sv
module conv_encoder_chk
  import conv_enc_pkg::*;
#(
  parameter int unsigned K     = 7,
  parameter int unsigned N_OUT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_bit,
  input logic             in_valid,
  input logic [N_OUT-1:0] out_code,
  input logic             out_valid
);
  localparam int unsigned LAT = enc_latency(K);

  logic [2:0] since_rst;
  logic [3:0] zero_run;     // accepted zeros in a row, saturating at K
  logic [LAT-1:0] zpipe;
  logic zero_win;

  assign zero_win = in_valid && !in_bit && (zero_run >= 4'(K - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      zero_run  <= 4'(K - 1);   // history is all zeros after reset (R7)
      zpipe     <= '0;
    end else begin
      if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
      if (in_valid) zero_run <= in_bit ? 4'd0 :
                               ((zero_run >= 4'(K)) ? zero_run : zero_run + 4'd1);
      zpipe <= {zpipe[LAT-2:0], zero_win};
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (out_valid == 1'b0 && out_code == '0)
        else $error("R1: outputs active during reset");
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)))
    else $error("R2: out_valid not aligned with delayed in_valid");

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && !out_valid) |-> $stable(out_code))
    else $error("R6: out_code moved while invalid");

  // R3 and R7: an all-zero window must code to an all-zero word
  assert_zero_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zpipe[LAT-1]) |-> (out_code == '0))
    else $error("R3: zero window gave a nonzero word");
endmodule

bind conv_encoder conv_encoder_chk #(.K(K), .N_OUT(N_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
  .out_code(out_code), .out_valid(out_valid)
);

// File: tb/conv_encoder_tb_top.sv
`timescale 1ns/1ps
module conv_encoder_tb_top;
  localparam int ND = 3;
  localparam int QD = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] code0, code1;
  logic [2:0] code2;
  logic [ND-1:0] vw;
  logic [7:0] cw [ND];

  // default: K=7, 171/133 octal
  conv_encoder dut_i (.clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
                      .out_code(code0), .out_valid(vw[0]));
  conv_encoder #(.K(3), .N_OUT(2), .POLYS({3'b101, 3'b111})) dut_k3_i (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .out_code(code1), .out_valid(vw[1]));
  conv_encoder #(.K(5), .N_OUT(3), .POLYS({5'b10111, 5'b11101, 5'b10011})) dut_k5_i (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .out_code(code2), .out_valid(vw[2]));

  assign cw[0] = {6'b0, code0};
  assign cw[1] = {6'b0, code1};
  assign cw[2] = {5'b0, code2};

  int cfg_k [ND];
  int cfg_n [ND];
  int cfg_lat [ND];
  logic [11:0] cfg_poly [ND][8];
  logic [10:0] hist [ND];
  logic [7:0] ecode [ND][QD];
  int ecyc [ND][QD];
  int hd [ND];
  int tl [ND];
  logic [7:0] last [ND];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] lf = 16'hACE1;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  // reference from R3/R4: window[K-1]=current, window[K-2]=most recent past
  function automatic logic [7:0] ref_code(int d, logic b);
    logic [11:0] win;
    logic [7:0] r;
    win = '0;
    for (int j = 0; j < cfg_k[d] - 1; j++) win[j] = hist[d][j];
    win[cfg_k[d]-1] = b;
    r = '0;
    for (int i = 0; i < cfg_n[d]; i++) r[i] = ^(win & cfg_poly[d][i]);
    return r;
  endfunction

  task automatic drive(input bit v, input bit b);
    @(negedge clk);
    in_valid = v;
    in_bit = b;
    if (v) begin
      for (int d = 0; d < ND; d++) begin
        ecode[d][tl[d]] = ref_code(d, b);
        ecyc[d][tl[d]] = cyc + cfg_lat[d];
        tl[d] = (tl[d] + 1) % QD;
        for (int j = 0; j < cfg_k[d] - 2; j++) hist[d][j] = hist[d][j+1];
        hist[d][cfg_k[d]-2] = b;
      end
    end
  endtask

  // scoreboard: R2 timing, R3/R4/R9 values, R6 hold
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < ND; d++) begin
        if (hd[d] != tl[d] && ecyc[d][hd[d]] == cyc) begin
          chk(vw[d] == 1'b1, "R2 word missing at expected cycle", {7'b0, vw[d]}, 8'h01);
          chk(cw[d] == ecode[d][hd[d]], "R3/R4/R9 code word", cw[d], ecode[d][hd[d]]);
          last[d] = cw[d];
          hd[d] = (hd[d] + 1) % QD;
        end else begin
          chk(vw[d] == 1'b0, "R2 unexpected valid", {7'b0, vw[d]}, 8'h00);
          chk(cw[d] == last[d], "R6 hold while invalid", cw[d], last[d]);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int d = 0; d < ND; d++) begin
      hd[d] = 0; tl[d] = 0; hist[d] = '0; last[d] = '0;  // R7 zero history
    end
    repeat (3) begin
      @(negedge clk);
      for (int d = 0; d < ND; d++) begin
        chk(vw[d] == 1'b0, "R1 valid in reset", {7'b0, vw[d]}, 8'h00);
        chk(cw[d] == 8'h00, "R1 code in reset", cw[d], 8'h00);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain(input string req);
    repeat (5) drive(1'b0, rnd());
    for (int d = 0; d < ND; d++)
      chk(hd[d] == tl[d], req, 8'(tl[d] - hd[d]), 8'h00);
  endtask

  task automatic t_reset_state();
    do_reset();
    drain("R1 no words after reset");
  endtask

  task automatic t_impulse();
    drive(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) drive(1'b1, 1'b0);
    drain("R3 impulse words delivered");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 300; i++) drive(1'b1, rnd());
    drain("R2 continuous stream delivered");
  endtask

  task automatic t_gaps();
    // idle cycles carry garbage on in_bit (R5, R8)
    for (int i = 0; i < 300; i++) begin
      bit v;
      v = rnd() | rnd();
      drive(v, rnd());
    end
    drain("R5/R8 gapped stream delivered");
  endtask

  task automatic t_ones_run();
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0);
    drain("R3 ones then zeros delivered");
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b1);
    do_reset();     // in-flight words are dropped
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drain("R7 history cleared by reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    cfg_k = '{7, 3, 5};
    cfg_n = '{2, 2, 3};
    cfg_lat = '{3, 2, 3};
    for (int d = 0; d < ND; d++) begin
      for (int i = 0; i < 8; i++) cfg_poly[d][i] = '0;
      hd[d] = 0; tl[d] = 0; hist[d] = '0; last[d] = '0;
    end
    cfg_poly[0][0] = 12'o171; cfg_poly[0][1] = 12'o133;
    cfg_poly[1][0] = 12'b111; cfg_poly[1][1] = 12'b101;
    cfg_poly[2][0] = 12'b10011; cfg_poly[2][1] = 12'b11101; cfg_poly[2][2] = 12'b10111;
    t_reset_state();
    t_impulse();
    t_stream();
    t_gaps();
    t_ones_run();
    t_mid_reset();
    t_gaps();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule